// File: doc/BRIEF.md
# Double-Precision Funnel Shifter with Status Flags

This unit shifts a destination operand left or right by a variable count, and fills the vacated bit positions from a second operand. The destination can be 16 or 32 bits wide. Each accepted operation produces a registered result one clock later, with a write strobe, and can also update four status flags: carry, zero, sign and even parity. A caller that does not want the flags changed can clear the flag-update input. The result is then still written and the flags stay as they were.

The shift count is taken modulo 32. A count that reduces to zero produces no write and leaves every flag alone. In 16-bit mode a reduced count above 16 has no defined outcome, so the unit suppresses both the result write and the flag update. The flag state is held inside the unit and persists from one operation to the next. Overflow and auxiliary-carry flags are not produced, which leaves them untouched.

Top module: `dshift_unit`

## Requirements
- R1: When `in_valid` is high and the raw `count_in` is 0, neither `res_we` nor `flags_we` rises in the next cycle, and the flag outputs keep their values.
- R2: Only the low 5 bits of `count_in` are used. A raw count of 33 behaves like 1, and a raw count of 32 behaves like 0, which means no write.
- R3: With `narrow_sel`=1 and a reduced count greater than 16, the result is not written and the flags are not updated.
- R4: With `dir_right`=0, the result is the destination shifted left by n, with its low n bits taken from the top n bits of `fill_in` at the selected width.
- R5: With `dir_right`=1, the result is the destination shifted right by n, with its high n bits taken from the low n bits of `fill_in`.
- R6: On a left shift, carry becomes destination bit (W − n), where W is 16 or 32.
- R7: On a right shift, carry becomes destination bit (n − 1).
- R8: On a flag update, zero is 1 exactly when the result at the selected width is all zeros.
- R9: On a flag update, sign equals result bit W − 1.
- R10: On a flag update, parity is 1 when bits 7..0 of the result hold an even number of ones.
- R11: With `flag_en`=0, a legal operation writes the result, `flags_we` stays low and all four flags keep their values.
- R12: In 16-bit mode, the operands are truncated to 16 bits and bits 31..16 of a written result are 0.
- R13: A legal operation presented in cycle T raises `res_we` for exactly cycle T+1. With `in_valid` low, nothing is written.
- R14: After reset, the result, both strobes and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| dst_in | input | 32 | Destination operand |
| fill_in | input | 32 | Fill-source operand |
| count_in | input | 8 | Raw shift count |
| dir_right | input | 1 | 1 = shift right, 0 = shift left |
| narrow_sel | input | 1 | 1 = 16-bit operands, 0 = 32-bit |
| flag_en | input | 1 | 1 = update flags with the result |
| res_out | output | 32 | Registered result |
| res_we | output | 1 | Result written this cycle |
| cf_out | output | 1 | Carry flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| pf_out | output | 1 | Parity flag (even) |
| flags_we | output | 1 | Flags updated this cycle |

## Verification
The bench builds the unit with its defaults: a 32-bit wide lane, a 16-bit narrow lane and an 8-bit raw count. The 8-bit count lets raw values of 32 and above be driven, so the modulo-32 reduction can be observed. Both lanes are active, so the out-of-range narrow counts 17 to 31 and the edge count of 16 can be reached alongside the full 1 to 31 range of the wide lane. Random operands are mixed with directed zero-result and full-width fill cases.

// File: rtl/dshift_pkg.sv
`timescale 1ns/1ps
package dshift_pkg;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic pf;
  } dsh_flags_t;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } dsh_dir_e;

  // even-parity indicator over one byte
  function automatic logic even_parity8(input logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/dshift_count_gate.sv
`timescale 1ns/1ps
module dshift_count_gate #(
  parameter int RAW_W    = 8,
  parameter int CNT_W    = 5,
  parameter int NARROW_W = 16
) (
  input  logic [RAW_W-1:0] raw_cnt,
  input  logic             narrow,
  output logic [CNT_W-1:0] eff_cnt,
  output logic             cnt_zero,
  output logic             cnt_over,
  output logic             cnt_legal
);
  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'(NARROW_W);

  always_comb begin
    eff_cnt   = raw_cnt[CNT_W-1:0];
    cnt_zero  = (eff_cnt == '0);
    cnt_over  = narrow && (eff_cnt > NARROW_MAX);
    cnt_legal = !cnt_zero && !cnt_over;
  end
endmodule

// File: rtl/dshift_funnel.sv
`timescale 1ns/1ps
module dshift_funnel #(
  parameter int W     = 32,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     dst,
  input  logic [W-1:0]     fill,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_r,
  output logic [W-1:0]     res,
  output logic             carry
);
  localparam int EXT_W = 2 * W + 1;

  logic [EXT_W-1:0] left_ext;
  logic [EXT_W-1:0] right_ext;

  // Left: {guard, dst, fill} shifted up; guard collects the last bit out.
  // Right: {fill, dst, guard} shifted down; guard collects the last bit out.
  always_comb begin
    left_ext  = {1'b0, dst, fill} << cnt;
    right_ext = {fill, dst, 1'b0} >> cnt;
    if (dir_r) begin
      res   = right_ext[W:1];
      carry = right_ext[0];
    end else begin
      res   = left_ext[2*W-1:W];
      carry = left_ext[2*W];
    end
  end
endmodule

// File: rtl/dshift_flag_calc.sv
`timescale 1ns/1ps
module dshift_flag_calc
  import dshift_pkg::*;
#(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [WIDE_W-1:0] res,
  input  logic              narrow,
  input  logic              carry,
  output dsh_flags_t        flags
);
  always_comb begin
    flags.cf = carry;
    flags.zf = (res == '0);
    flags.sf = narrow ? res[NARROW_W-1] : res[WIDE_W-1];
    flags.pf = even_parity8(res[7:0]);
  end
endmodule

// File: rtl/dshift_unit.sv
`timescale 1ns/1ps
module dshift_unit
  import dshift_pkg::*;
#(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int RAW_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WIDE_W-1:0] dst_in,
  input  logic [WIDE_W-1:0] fill_in,
  input  logic [RAW_W-1:0]  count_in,
  input  logic              dir_right,
  input  logic              narrow_sel,
  input  logic              flag_en,
  output logic [WIDE_W-1:0] res_out,
  output logic              res_we,
  output logic              cf_out,
  output logic              zf_out,
  output logic              sf_out,
  output logic              pf_out,
  output logic              flags_we
);
  localparam int CNT_W   = $clog2(WIDE_W);
  localparam int N_LANES = 2;

  logic [CNT_W-1:0]  eff_cnt;
  logic              cnt_zero, cnt_over, cnt_legal;
  logic              op_fire, flag_fire;
  logic [WIDE_W-1:0] lane_res   [N_LANES];
  logic              lane_carry [N_LANES];
  logic [WIDE_W-1:0] sel_res;
  logic              sel_carry;
  dsh_flags_t        next_flags, flags_q;

  dshift_count_gate #(
    .RAW_W(RAW_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W)
  ) u_gate (
    .raw_cnt  (count_in),
    .narrow   (narrow_sel),
    .eff_cnt  (eff_cnt),
    .cnt_zero (cnt_zero),
    .cnt_over (cnt_over),
    .cnt_legal(cnt_legal)
  );

  // lane 0 = narrow width, lane 1 = wide width
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] lres;
    dshift_funnel #(.W(LW), .CNT_W(CNT_W)) u_funnel (
      .dst  (dst_in[LW-1:0]),
      .fill (fill_in[LW-1:0]),
      .cnt  (eff_cnt),
      .dir_r(dir_right),
      .res  (lres),
      .carry(lane_carry[g])
    );
    if (LW < WIDE_W) begin : g_pad
      assign lane_res[g] = {{(WIDE_W-LW){1'b0}}, lres};
    end else begin : g_full
      assign lane_res[g] = lres;
    end
  end

  assign sel_res   = narrow_sel ? lane_res[0]   : lane_res[1];
  assign sel_carry = narrow_sel ? lane_carry[0] : lane_carry[1];
  assign op_fire   = in_valid && cnt_legal;
  assign flag_fire = op_fire && flag_en;

  dshift_flag_calc #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_flags (
    .res   (sel_res),
    .narrow(narrow_sel),
    .carry (sel_carry),
    .flags (next_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out  <= '0;
      res_we   <= 1'b0;
      flags_q  <= '0;
      flags_we <= 1'b0;
    end else begin
      res_we   <= op_fire;
      flags_we <= flag_fire;
      if (op_fire)   res_out <= sel_res;
      if (flag_fire) flags_q <= next_flags;
    end
  end

  assign cf_out = flags_q.cf;
  assign zf_out = flags_q.zf;
  assign sf_out = flags_q.sf;
  assign pf_out = flags_q.pf;
endmodule

// File: rtl/dshift_unit_chk.sv
`timescale 1ns/1ps
module dshift_unit_chk #(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int RAW_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [RAW_W-1:0]  count_in,
  input logic              narrow_sel,
  input logic              flag_en,
  input logic              op_fire,
  input logic [WIDE_W-1:0] res_out,
  input logic              res_we,
  input logic              cf_out,
  input logic              zf_out,
  input logic              sf_out,
  input logic              pf_out,
  input logic              flags_we
);
  localparam int CNT_W = $clog2(WIDE_W);

  // R1
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count_in == '0) |=> (!res_we && !flags_we));

  // R3
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && narrow_sel && (count_in[CNT_W-1:0] > CNT_W'(NARROW_W)))
      |=> (!res_we && !flags_we));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_we |-> $stable({cf_out, zf_out, sf_out, pf_out}));

  // R11
  flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flag_en) |=> !flags_we);

  // R13
  fire_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> res_we);

  // R13
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_we && !flags_we));

  // R12
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && $past(narrow_sel)) |-> (res_out[WIDE_W-1:NARROW_W] == '0));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (zf_out == (res_out == '0)));

  // R10
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (pf_out == ~^res_out[7:0]));

  // R9
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (sf_out == ($past(narrow_sel) ? res_out[NARROW_W-1] : res_out[WIDE_W-1])));

  // R11
  flag_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> res_we);
endmodule

bind dshift_unit dshift_unit_chk #(
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .RAW_W(RAW_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .count_in  (count_in),
  .narrow_sel(narrow_sel),
  .flag_en   (flag_en),
  .op_fire   (op_fire),
  .res_out   (res_out),
  .res_we    (res_we),
  .cf_out    (cf_out),
  .zf_out    (zf_out),
  .sf_out    (sf_out),
  .pf_out    (pf_out),
  .flags_we  (flags_we)
);

// File: tb/dshift_unit_test.sv
`timescale 1ns/1ps
module dshift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] dst_in = '0, fill_in = '0;
  logic [7:0]  count_in = '0;
  logic        dir_right = 1'b0, narrow_sel = 1'b0, flag_en = 1'b0;
  logic [31:0] res_out;
  logic        res_we, cf_out, zf_out, sf_out, pf_out, flags_we;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;
  logic [3:0] m_flags = 4'b0000; // {cf, zf, sf, pf}

  always #10 clk = ~clk;

  dshift_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_in(dst_in),
    .fill_in(fill_in), .count_in(count_in), .dir_right(dir_right),
    .narrow_sel(narrow_sel), .flag_en(flag_en), .res_out(res_out),
    .res_we(res_we), .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out),
    .pf_out(pf_out), .flags_we(flags_we)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bit-by-bit restatement of the shift
  function automatic logic [31:0] ref_result(input logic [31:0] d, input logic [31:0] f,
                                             input int n, input bit rt, input int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++) begin
      if (rt) r[i] = (i + n < w) ? d[i + n] : f[i + n - w];
      else    r[i] = (i >= n)    ? d[i - n] : f[w - n + i];
    end
    return r;
  endfunction

  function automatic bit ref_parity(input logic [31:0] r);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    return (ones % 2) == 0;
  endfunction

  task automatic do_op(input logic [31:0] d, input logic [31:0] f, input logic [7:0] c,
                       input bit rt, input bit nar, input bit fen);
    int n, w;
    bit legal;
    logic [31:0] er, hold_res;
    logic [3:0] ef;
    hold_res = res_out;
    @(negedge clk);
    dst_in = d; fill_in = f; count_in = c; dir_right = rt;
    narrow_sel = nar; flag_en = fen; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n = int'(c) % 32;
    w = nar ? 16 : 32;
    legal = (n != 0) && !(nar && n > 16);
    if (c == 0)
      check("R1", "res_we on zero count", {31'b0, res_we}, 32'd0);
    else if (n == 0)
      check("R2", "res_we on count 32", {31'b0, res_we}, 32'd0);
    else if (!legal)
      check("R3", "res_we on narrow overrange", {31'b0, res_we}, 32'd0);
    else
      check("R13", "res_we on legal op", {31'b0, res_we}, 32'd1);
    if (legal) begin
      er = ref_result(d & (nar ? 32'h0000_ffff : 32'hffff_ffff),
                      f & (nar ? 32'h0000_ffff : 32'hffff_ffff), n, rt, w);
      check(rt ? "R5" : "R4", "result", res_out, er);
      if (nar) check("R12", "upper bits", {16'b0, res_out[31:16]}, 32'd0);
      if (fen) begin
        ef[3] = rt ? d[n - 1] : d[w - n];
        ef[2] = (er == 0);
        ef[1] = er[w - 1];
        ef[0] = ref_parity(er);
        m_flags = ef;
      end
    end else begin
      check("R3", "result held", res_out, hold_res);
    end
    check((legal && fen) ? "R13" : "R11", "flags_we",
          {31'b0, flags_we}, {31'b0, legal && fen});
    check(rt ? "R7" : "R6", "carry", {31'b0, cf_out}, {31'b0, m_flags[3]});
    check("R8",  "zero",   {31'b0, zf_out}, {31'b0, m_flags[2]});
    check("R9",  "sign",   {31'b0, sf_out}, {31'b0, m_flags[1]});
    check("R10", "parity", {31'b0, pf_out}, {31'b0, m_flags[0]});
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R14 reset state
    check("R14", "res_out", res_out, 32'd0);
    check("R14", "strobes", {30'b0, res_we, flags_we}, 32'd0);
    check("R14", "flags", {28'b0, cf_out, zf_out, sf_out, pf_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // set a known flag state, then zero/illegal counts must keep it
    do_op(32'h8000_0001, 32'hffff_0000, 8'd4, 1'b0, 1'b0, 1'b1);
    do_op(32'h1234_5678, 32'h9abc_def0, 8'd0, 1'b0, 1'b0, 1'b1);   // R1
    do_op(32'h1234_5678, 32'h9abc_def0, 8'd32, 1'b1, 1'b0, 1'b1);  // R2
    do_op(32'h1234_5678, 32'h9abc_def0, 8'd33, 1'b1, 1'b0, 1'b1);  // R2 acts as 1
    do_op(32'h0000_ffff, 32'h0000_1234, 8'd17, 1'b0, 1'b1, 1'b1);  // R3
    do_op(32'h0000_ffff, 32'h0000_1234, 8'd31, 1'b1, 1'b1, 1'b1);  // R3
    do_op(32'hdead_8001, 32'hbeef_a5a5, 8'd16, 1'b0, 1'b1, 1'b1);  // R6 edge count
    do_op(32'hdead_8001, 32'hbeef_a5a5, 8'd16, 1'b1, 1'b1, 1'b1);  // R7 edge count
    do_op(32'h0000_0000, 32'h0000_0000, 8'd5, 1'b0, 1'b0, 1'b1);   // R8 zero result
    do_op(32'hffff_ffff, 32'h0000_0000, 8'd31, 1'b1, 1'b0, 1'b1);  // R7 wide max
    do_op(32'h4000_0000, 32'h0, 8'd1, 1'b0, 1'b0, 1'b1);           // R9 sign set
    do_op(32'h5555_5555, 32'h0f0f_0f0f, 8'd3, 1'b0, 1'b0, 1'b0);   // R11 flags held
    do_op(32'haaaa_0000, 32'h0000_0003, 8'd2, 1'b1, 1'b1, 1'b0);   // R11 narrow
    // R13 idle: nonzero count without in_valid writes nothing
    @(negedge clk);
    count_in = 8'd7; in_valid = 1'b0;
    @(negedge clk);
    check("R13", "idle res_we", {30'b0, res_we, flags_we}, 32'd0);

    for (int k = 0; k < 600; k++) begin
      logic [7:0] c;
      c = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 33);
      do_op($urandom, $urandom, c, 1'($urandom), 1'($urandom), ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule